// File: doc/BRIEF.md
# Sliced Hypervector Feature Encoder

This block turns one sample of quantized features into a binary hypervector, one fixed-width slice at a time. A controller pulses `start_i` with the index of the slice it wants, then streams the sample's feature values over a valid/ready handshake, one feature per cycle. For every feature the block regenerates, on the fly, the pseudo-random identity code of that feature and the level code of its value, for the selected slice only. It binds the two codes with a bitwise XOR and adds the bound bits into one small counter per dimension.

After the last feature of the sample, each counter is reduced to a single bit by a majority threshold. The binarized slice comes out as a one-cycle pulse. Because every code is a pure function of feature index, slice index and level, no item memory is stored. The controller covers the whole hypervector by repeating the sample once per slice index.

Top module: `hv_slice_encoder`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid_o` is 0, `feat_ready_o` is 0 and `out_bits_o` and `out_slice_o` are all zeros until the first result.
- R2: A `start_i` pulse while idle latches `slice_sel_i`, and `feat_ready_o` is 1 in the following cycle.
- R3: `start_i` while a sample is in progress is ignored: the slice index and the features already added are unchanged.
- R4: Features are accepted on cycles with `feat_valid_i` and `feat_ready_o` both high. The k-th accepted feature (from 0) has feature index k. After the NUM_FEAT-th acceptance `feat_ready_o` drops, and in the very next cycle `out_valid_o` is 1 for exactly one cycle with `out_slice_o` equal to the latched slice index.
- R5: Word w (bits 32w+31..32w) of the identity slice of feature f in slice s is G(0,f,s,w). Here G(t,f,s,w) = X(X(X((0x9E3779B9 ^ f*0x85EBCA6B ^ s*0xC2B2AE35 ^ w*0x27D4EB2F ^ (t ? 0x165667B1 : 0)) | 1))). X(x) applies x^=x<<13, x^=x>>17, x^=x<<5, all mod 2^32.
- R6: Word w of the level-0 code of slice s is G(1,0,s,w).
- R7: Level L equals level 0 with bit p inverted exactly when q(p) < F*L, where q(p) = (77*p) mod SLICE_W and F = floor(SLICE_W/(2*(NUM_LEVELS-1))) (11 for the defaults). Adjacent levels therefore differ in F bits.
- R8: Output bit p is 1 when the count over all features of (identity bit p XOR level bit p) times 2 exceeds NUM_FEAT. An exact tie gives 0.
- R9: A feature value of NUM_LEVELS or more is treated as level NUM_LEVELS-1.
- R10: Between result pulses `out_bits_o` and `out_slice_o` hold their last value.
- R11: Cycles with `feat_valid_i` low do not count as features and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one sample for one slice |
| slice_sel_i | input | $clog2(NUM_SLICES) | Slice index latched on start |
| feat_valid_i | input | 1 | Feature value present |
| feat_level_i | input | $clog2(NUM_LEVELS) | Quantized feature value |
| feat_ready_o | output | 1 | Block accepts a feature this cycle |
| out_valid_o | output | 1 | One-cycle result pulse |
| out_slice_o | output | $clog2(NUM_SLICES) | Slice index of the result |
| out_bits_o | output | SLICE_W | Binarized slice |

## Verification
A wrong feature counter or wrong slice register shows at the ports in the same sample. The pulse arrives a cycle early or late, or its slice tag is wrong, and each of these is caught at the pulse. A wrong identity bit, flip position or counter value surfaces only as a bad output bit at the end of the sample. Each result is therefore compared whole against a model built from the generator and threshold rules. Tie bits, clamped levels, stalls and starts issued while busy are each aimed at a case where one mistake flips a visible bit.

// File: rtl/hv_enc_pkg.sv
package hv_enc_pkg;

    localparam int DEF_SLICE_W    = 256;
    localparam int DEF_NUM_SLICES = 32;
    localparam int DEF_NUM_LEVELS = 12;
    localparam int DEF_NUM_FEAT   = 8;
    localparam int PERM_STEP      = 77;   // odd, so the map is a bijection

    localparam logic [31:0] K_GOLD  = 32'h9E3779B9;
    localparam logic [31:0] K_FEAT  = 32'h85EBCA6B;
    localparam logic [31:0] K_SLICE = 32'hC2B2AE35;
    localparam logic [31:0] K_WORD  = 32'h27D4EB2F;
    localparam logic [31:0] K_TAG   = 32'h165667B1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } enc_state_e;

    function automatic logic [31:0] xs_round(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] code_word(input logic        tag,
                                              input logic [31:0] feat,
                                              input logic [31:0] slice,
                                              input logic [31:0] word);
        logic [31:0] seed;
        seed = K_GOLD ^ (feat * K_FEAT) ^ (slice * K_SLICE) ^ (word * K_WORD)
               ^ (tag ? K_TAG : 32'h0);
        return xs_round(xs_round(xs_round(seed | 32'h1)));
    endfunction

endpackage

// File: rtl/hv_code_gen.sv
module hv_code_gen
    import hv_enc_pkg::*;
#(
    parameter int SLICE_W    = DEF_SLICE_W,
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int FIDX_W     = 3,
    parameter int SIDX_W     = 5,
    parameter int LVL_W      = 4
) (
    input  logic [FIDX_W-1:0]  feat_idx_i,
    input  logic [SIDX_W-1:0]  slice_idx_i,
    input  logic [LVL_W-1:0]   level_i,
    output logic [SLICE_W-1:0] id_code_o,
    output logic [SLICE_W-1:0] lvl_code_o
);
    localparam int WORDS    = SLICE_W / 32;
    localparam int FLIP_GRP = SLICE_W / (2 * (NUM_LEVELS - 1));

    logic [SLICE_W-1:0] base_code;
    logic [SLICE_W-1:0] flip_mask;
    int                 flip_lim;

    assign flip_lim = int'(level_i) * FLIP_GRP;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign id_code_o[32*w +: 32] =
            code_word(1'b0, 32'(feat_idx_i), 32'(slice_idx_i), 32'(w));
        assign base_code[32*w +: 32] =
            code_word(1'b1, 32'h0, 32'(slice_idx_i), 32'(w));
    end

    for (genvar p = 0; p < SLICE_W; p++) begin : g_bit
        localparam int PERM_POS = (p * PERM_STEP) % SLICE_W;
        assign flip_mask[p] = (PERM_POS < flip_lim);
    end

    assign lvl_code_o = base_code ^ flip_mask;

endmodule

// File: rtl/hv_bundle_accum.sv
module hv_bundle_accum
    import hv_enc_pkg::*;
#(
    parameter int SLICE_W  = DEF_SLICE_W,
    parameter int NUM_FEAT = DEF_NUM_FEAT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               add_i,
    input  logic               last_i,
    input  logic [SLICE_W-1:0] bound_i,
    output logic [SLICE_W-1:0] bits_o,
    output logic               valid_o
);
    localparam int CW = $clog2(NUM_FEAT + 1);

    logic [CW-1:0]      cnt_q  [SLICE_W];
    logic [CW-1:0]      cnt_nx [SLICE_W];
    logic [SLICE_W-1:0] bits_q;
    logic               valid_q;

    always_comb begin
        for (int d = 0; d < SLICE_W; d++) begin
            cnt_nx[d] = cnt_q[d] + CW'(bound_i[d]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < SLICE_W; d++) cnt_q[d] <= '0;
            bits_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= add_i && last_i;
            if (clear_i) begin
                for (int d = 0; d < SLICE_W; d++) cnt_q[d] <= '0;
            end else if (add_i) begin
                for (int d = 0; d < SLICE_W; d++) cnt_q[d] <= cnt_nx[d];
                if (last_i) begin
                    for (int d = 0; d < SLICE_W; d++)
                        bits_q[d] <= (2 * int'(cnt_nx[d])) > NUM_FEAT;
                end
            end
        end
    end

    assign bits_o  = bits_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/hv_slice_encoder.sv
module hv_slice_encoder
    import hv_enc_pkg::*;
#(
    parameter int SLICE_W    = DEF_SLICE_W,
    parameter int NUM_SLICES = DEF_NUM_SLICES,
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int NUM_FEAT   = DEF_NUM_FEAT
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [$clog2(NUM_SLICES)-1:0] slice_sel_i,
    input  logic                          feat_valid_i,
    input  logic [$clog2(NUM_LEVELS)-1:0] feat_level_i,
    output logic                          feat_ready_o,
    output logic                          out_valid_o,
    output logic [$clog2(NUM_SLICES)-1:0] out_slice_o,
    output logic [SLICE_W-1:0]            out_bits_o
);
    localparam int SIDX_W = $clog2(NUM_SLICES);
    localparam int LVL_W  = $clog2(NUM_LEVELS);
    localparam int FIDX_W = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1;

    enc_state_e         state_q;
    logic [SIDX_W-1:0]  slice_q;
    logic [SIDX_W-1:0]  out_slice_q;
    logic [FIDX_W-1:0]  feat_q;
    logic [LVL_W-1:0]   level_c;
    logic               accept;
    logic               last_feat;
    logic               launch;
    logic [SLICE_W-1:0] id_code;
    logic [SLICE_W-1:0] lvl_code;

    assign launch    = (state_q == ST_IDLE) && start_i;
    assign accept    = (state_q == ST_RUN) && feat_valid_i;
    assign last_feat = (feat_q == FIDX_W'(NUM_FEAT - 1));
    assign level_c   = (int'(feat_level_i) >= NUM_LEVELS) ? LVL_W'(NUM_LEVELS - 1)
                                                          : feat_level_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            slice_q     <= '0;
            feat_q      <= '0;
            out_slice_q <= '0;
        end else if (launch) begin
            state_q <= ST_RUN;
            slice_q <= slice_sel_i;
            feat_q  <= '0;
        end else if (accept) begin
            feat_q <= feat_q + FIDX_W'(1);
            if (last_feat) begin
                state_q     <= ST_IDLE;
                out_slice_q <= slice_q;
            end
        end
    end

    hv_code_gen #(
        .SLICE_W   (SLICE_W),
        .NUM_LEVELS(NUM_LEVELS),
        .FIDX_W    (FIDX_W),
        .SIDX_W    (SIDX_W),
        .LVL_W     (LVL_W)
    ) u_gen (
        .feat_idx_i (feat_q),
        .slice_idx_i(slice_q),
        .level_i    (level_c),
        .id_code_o  (id_code),
        .lvl_code_o (lvl_code)
    );

    hv_bundle_accum #(
        .SLICE_W (SLICE_W),
        .NUM_FEAT(NUM_FEAT)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear_i(launch),
        .add_i  (accept),
        .last_i (last_feat),
        .bound_i(id_code ^ lvl_code),
        .bits_o (out_bits_o),
        .valid_o(out_valid_o)
    );

    assign feat_ready_o = (state_q == ST_RUN);
    assign out_slice_o  = out_slice_q;

endmodule

// File: rtl/hv_enc_checker.sv
module hv_enc_checker #(
    parameter int SLICE_W  = 256,
    parameter int SIDX_W   = 5,
    parameter int NUM_FEAT = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               feat_valid_i,
    input logic               feat_ready_o,
    input logic               out_valid_o,
    input logic [SIDX_W-1:0]  out_slice_o,
    input logic [SLICE_W-1:0] out_bits_o
);
    int seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 0;
        else if (start_i && !feat_ready_o) seen_q <= 0;
        else if (feat_valid_i && feat_ready_o) seen_q <= seen_q + 1;
    end

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !feat_ready_o && !out_valid_o) |=> feat_ready_o); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (feat_ready_o && !feat_valid_i) |=> feat_ready_o); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |=> !out_valid_o); // R4
    AST_NO_READY_AT_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> !feat_ready_o); // R4
    AST_FEAT_COUNT: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (seen_q == NUM_FEAT)); // R11
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> ($stable(out_bits_o) && $stable(out_slice_o))); // R10

endmodule

bind hv_slice_encoder hv_enc_checker #(
    .SLICE_W (SLICE_W),
    .SIDX_W  ($clog2(NUM_SLICES)),
    .NUM_FEAT(NUM_FEAT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .feat_valid_i(feat_valid_i),
    .feat_ready_o(feat_ready_o),
    .out_valid_o (out_valid_o),
    .out_slice_o (out_slice_o),
    .out_bits_o  (out_bits_o)
);

// File: tb/sim_hv_slice_encoder.sv
module sim_hv_slice_encoder;
    localparam int W  = 256;
    localparam int NS = 32;
    localparam int NL = 12;
    localparam int NF = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [4:0]   slice_sel_i = '0;
    logic         feat_valid_i = 1'b0;
    logic [3:0]   feat_level_i = '0;
    logic         feat_ready_o;
    logic         out_valid_o;
    logic [4:0]   out_slice_o;
    logic [W-1:0] out_bits_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    hv_slice_encoder #(.SLICE_W(W), .NUM_SLICES(NS), .NUM_LEVELS(NL), .NUM_FEAT(NF)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .slice_sel_i(slice_sel_i),
        .feat_valid_i(feat_valid_i), .feat_level_i(feat_level_i),
        .feat_ready_o(feat_ready_o), .out_valid_o(out_valid_o),
        .out_slice_o(out_slice_o), .out_bits_o(out_bits_o)
    );

    // stimulus: {slice[4:0], lvl0, lvl1, lvl2, lvl3}
    localparam int NVEC = 8;
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd0,  4'd0,  4'd0,  4'd0,  4'd0},
        {5'd0,  4'd11, 4'd11, 4'd11, 4'd11},
        {5'd31, 4'd3,  4'd7,  4'd1,  4'd10},
        {5'd5,  4'd0,  4'd1,  4'd2,  4'd3},
        {5'd5,  4'd0,  4'd1,  4'd2,  4'd4},
        {5'd17, 4'd6,  4'd6,  4'd5,  4'd5},
        {5'd9,  4'd11, 4'd0,  4'd11, 4'd0},
        {5'd30, 4'd2,  4'd9,  4'd4,  4'd8}
    };

    function automatic logic [31:0] rnd(input logic [31:0] v);
        logic [31:0] a;
        a = v;
        for (int k = 0; k < 3; k++) begin
            a = a ^ (a << 13);
            a = a ^ (a >> 17);
            a = a ^ (a << 5);
        end
        return a;
    endfunction

    function automatic logic [31:0] gw(input int t, input int f, input int s, input int w);
        logic [31:0] sd;
        sd = 32'h9E3779B9 ^ (32'(f) * 32'h85EBCA6B) ^ (32'(s) * 32'hC2B2AE35)
             ^ (32'(w) * 32'h27D4EB2F) ^ ((t != 0) ? 32'h165667B1 : 32'h0);
        return rnd(sd | 32'h1);
    endfunction

    function automatic logic [W-1:0] model(input int s, input logic [15:0] lv);
        logic [W-1:0] r;
        r = '0;
        for (int p = 0; p < W; p++) begin
            int cnt;
            cnt = 0;
            for (int f = 0; f < NF; f++) begin
                int lvl;
                logic idb, bb, fl;
                lvl = int'(lv[15-4*f -: 4]);
                if (lvl > NL - 1) lvl = NL - 1;
                idb = gw(0, f, s, p / 32)[p % 32];
                bb  = gw(1, 0, s, p / 32)[p % 32];
                fl  = ((p * 77) % W) < (W / (2 * (NL - 1))) * lvl;
                cnt += int'(idb ^ bb ^ fl);
            end
            r[p] = (2 * cnt > NF);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode 0 plain, 1 stall, 2 start while busy
    task automatic run(input int s, input logic [15:0] lv, input int mode, input string req);
        logic [W-1:0] e;
        e = model(s, lv);
        @(negedge clk);
        start_i = 1'b1; slice_sel_i = 5'(s);
        @(negedge clk);
        start_i = 1'b0;
        chk(feat_ready_o === 1'b1, "R2", W'(feat_ready_o), W'(1));
        for (int f = 0; f < NF; f++) begin
            if (mode == 1 && f == 2) begin
                feat_valid_i = 1'b0; feat_level_i = 4'd0;
                repeat (2) @(negedge clk);
            end
            feat_valid_i = 1'b1; feat_level_i = lv[15-4*f -: 4];
            if (mode == 2 && f == 1) begin
                start_i = 1'b1; slice_sel_i = 5'(s ^ 7);
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        feat_valid_i = 1'b0;
        chk(out_valid_o === 1'b1 && feat_ready_o === 1'b0, "R4 pulse", W'({out_valid_o, feat_ready_o}), W'(2));
        chk(out_slice_o === 5'(s), "R4 slice", W'(out_slice_o), W'(s));
        chk(out_bits_o === e, req, out_bits_o, e);
        @(negedge clk);
        chk(out_valid_o === 1'b0, "R4 single", W'(out_valid_o), W'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid_o === 1'b0 && feat_ready_o === 1'b0, "R1", W'({out_valid_o, feat_ready_o}), W'(0));
        chk(out_bits_o === '0 && out_slice_o === '0, "R1", out_bits_o, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid_o === 1'b0 && feat_ready_o === 1'b0, "R1", W'({out_valid_o, feat_ready_o}), W'(0));

        // table: identity (R5), level base (R6), flip mask (R7), threshold and ties (R8)
        for (int i = 0; i < NVEC; i++)
            run(int'(VEC[i][20:16]), VEC[i][15:0], 0, "R5 R6 R7 R8 bits");

        // R9: values above the top level clamp
        run(12, {4'd15, 4'd12, 4'd13, 4'd11}, 0, "R9 clamp");
        chk(model(12, {4'd15, 4'd12, 4'd13, 4'd11}) === model(12, {4'd11, 4'd11, 4'd11, 4'd11}),
            "R9 model", '0, '0);

        // R11: idle valid cycles inside a sample
        run(21, {4'd1, 4'd8, 4'd3, 4'd11}, 1, "R11 stall");

        // R3: start during a sample is ignored
        run(14, {4'd4, 4'd9, 4'd0, 4'd6}, 2, "R3 busy start");

        // R10: outputs hold while idle
        held = out_bits_o;
        repeat (4) @(negedge clk);
        chk(out_bits_o === held && out_valid_o === 1'b0 && out_slice_o === 5'd14,
            "R10 hold", out_bits_o, held);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule